// File: doc/BRIEF.md
# Option ROM/RAM Overlay Pager

This block serves an 8 KiB option-ROM window on the system bus. The lower 6 KiB of the window always read from ROM. The upper 2 KiB can show either the ROM's own top bytes or a 2 KiB scratch RAM, chosen by a single page flag. Memory offsets from 8 KiB up to the 16 KiB decode limit read as all ones.

Firmware switches the flag through one I/O port at 0x2DD, and the direction of the access is what matters. Any write, whatever its data, exposes the RAM. Any read exposes the ROM and returns the flag as it stood before that read. Firmware can therefore save its settings in the RAM, page the ROM in to fetch font data, and learn which bank it displaced.

Bus accesses take one cycle. The block samples the strobe at a rising clock edge. The page flag and the RAM update on that same edge, and the read data appears on `rdata_o` after it. Read data therefore always reflects the page state from before the access.

Top module: `pager_overlay`

## Requirements
- R1: Reset selects ROM and sets `rdata_o` to 0xFF. The first read of port 0x2DD after reset returns 0x80.
- R2: A memory read at offset `a` (`addr_i[13:0]`) below 0x1800 returns the ROM byte `a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A`. The data appears on `rdata_o` at the clock edge that samples `req_i`.
- R3: An I/O read of port 0x2DD selects ROM. It returns 0x80 if ROM was selected before the read and 0x00 if RAM was.
- R4: An I/O write to port 0x2DD selects RAM, whatever the write data.
- R5: With RAM selected, a memory read at offsets 0x1800-0x1FFF returns RAM byte `a & 0x7FF`. After reset each RAM byte equals the ROM byte at 0x1800 plus its index.
- R6: With ROM selected, a memory read at offsets 0x1800-0x1FFF returns the ROM byte at that offset.
- R7: A memory read at offsets 0x2000-0x3FFF returns 0xFF.
- R8: A memory write stores into RAM only when its offset lies in 0x1800-0x1FFF and RAM is selected. All other memory writes change nothing that a later read can see.
- R9: An I/O access to any port other than 0x2DD leaves the page flag unchanged. Such a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| io_i | input | 1 | 1 = I/O space, 0 = memory window |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | I/O port number, or memory offset in bits 13:0 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered, held until the next read |

## Verification
The bench sweeps every memory offset of the 16 KiB decode with ROM selected. This catches a bad ROM formula, an off-by-one at the 0x1800 and 0x2000 boundaries, or a high region that aliases the window instead of reading 0xFF. It then fills the whole overlay while RAM is selected and reads it back. A design that decoded the RAM index from the wrong bits, or that let writes below 0x1800 or above 0x1FFF land in RAM, would return the wrong bytes. The bench also writes the overlay with ROM selected and checks that the RAM copy survives, which a design that ignored the page flag on writes would fail. Port reads in both states check the returned previous state; a design that returned the new state would read 0x80 where 0x00 is due. Neighbouring ports are accessed and must leave the flag alone.

// File: rtl/pager_pkg.sv
package pager_pkg;
  // ROM content is a fixed function of the offset
  function automatic logic [7:0] rom_byte(input logic [31:0] off, input logic [7:0] seed);
    return off[7:0] ^ {3'b000, off[12:8]} ^ seed;
  endfunction
endpackage

// File: rtl/pager_rom.sv
module pager_rom #(
  parameter int unsigned  ADDR_W   = 14,
  parameter logic [7:0]   ROM_SEED = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  always_comb data_o = pager_pkg::rom_byte(32'(addr_i), ROM_SEED);
endmodule

// File: rtl/pager_ram.sv
module pager_ram #(
  parameter int unsigned OVL_BYTES = 2048,
  parameter int unsigned OVL_BASE  = 6144,
  parameter logic [7:0]  ROM_SEED  = 8'h5A,
  localparam int unsigned OVL_AW   = $clog2(OVL_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OVL_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [OVL_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [OVL_BYTES];

  // reset loads a copy of the ROM bytes the overlay shadows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < OVL_BYTES; i++)
        mem_q[i] <= pager_pkg::rom_byte(32'(OVL_BASE + i), ROM_SEED);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pager_page_ctl.sv
module pager_page_ctl #(
  parameter int unsigned  IO_W      = 16,
  parameter logic [IO_W-1:0] PAGE_PORT = 16'h02DD
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            io_i,
  input  logic            we_i,
  input  logic [IO_W-1:0] addr_i,
  output logic            port_hit_o,
  output logic            rom_sel_o
);
  logic rom_sel_q;

  assign port_hit_o = req_i && io_i && (addr_i == PAGE_PORT);

  // read pages ROM in, write pages RAM in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rom_sel_q <= 1'b1;
    else if (port_hit_o) rom_sel_q <= !we_i;
  end

  assign rom_sel_o = rom_sel_q;

  assert_port_read_rom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && io_i && !we_i && addr_i == PAGE_PORT) |=> rom_sel_q);
  assert_port_write_ram_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && io_i && we_i && addr_i == PAGE_PORT) |=> !rom_sel_q);
  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && io_i && addr_i == PAGE_PORT) |=> $stable(rom_sel_q));
endmodule

// File: rtl/pager_overlay.sv
module pager_overlay #(
  parameter int unsigned     ADDR_W    = 14,
  parameter int unsigned     IO_W      = 16,
  parameter int unsigned     WIN_BYTES = 8192,
  parameter int unsigned     OVL_BYTES = 2048,
  parameter logic [IO_W-1:0] PAGE_PORT = 16'h02DD,
  parameter logic [7:0]      ROM_SEED  = 8'h5A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            io_i,
  input  logic            we_i,
  input  logic [IO_W-1:0] addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o
);
  localparam int unsigned OVL_AW   = $clog2(OVL_BYTES);
  localparam int unsigned OVL_BASE = WIN_BYTES - OVL_BYTES;
  localparam logic [ADDR_W-1:0] OVL_LO = ADDR_W'(OVL_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BYTES);

  logic [ADDR_W-1:0] off;
  logic              in_win, in_ovl, port_hit, rom_sel, ram_we;
  logic [7:0]        rom_data, ram_data, mem_data, rdata_q;

  assign off    = addr_i[ADDR_W-1:0];
  assign in_win = off < WIN_HI;
  assign in_ovl = in_win && (off >= OVL_LO);

  pager_page_ctl #(.IO_W(IO_W), .PAGE_PORT(PAGE_PORT)) u_ctl (
    .clk_i, .rst_ni, .req_i, .io_i, .we_i, .addr_i,
    .port_hit_o(port_hit), .rom_sel_o(rom_sel)
  );

  pager_rom #(.ADDR_W(ADDR_W), .ROM_SEED(ROM_SEED)) u_rom (
    .addr_i(off), .data_o(rom_data)
  );

  assign ram_we = req_i && !io_i && we_i && in_ovl && !rom_sel;

  pager_ram #(.OVL_BYTES(OVL_BYTES), .OVL_BASE(OVL_BASE), .ROM_SEED(ROM_SEED)) u_ram (
    .clk_i, .rst_ni,
    .we_i(ram_we), .waddr_i(off[OVL_AW-1:0]), .wdata_i,
    .raddr_i(off[OVL_AW-1:0]), .rdata_o(ram_data)
  );

  always_comb begin
    if (!in_win)                 mem_data = 8'hFF;
    else if (in_ovl && !rom_sel) mem_data = ram_data;
    else                         mem_data = rom_data;
  end

  // read data uses the page state from before this access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= 8'hFF;
    else if (req_i && !we_i) begin
      if (!io_i)         rdata_q <= mem_data;
      else if (port_hit) rdata_q <= rom_sel ? 8'h80 : 8'h00;
      else               rdata_q <= 8'hFF;
    end
  end

  assign rdata_o = rdata_q;

  assert_prev_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && io_i && !we_i && addr_i == PAGE_PORT) |=> rdata_o == ($past(rom_sel) ? 8'h80 : 8'h00));
  assert_high_ff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !io_i && !we_i && !in_win) |=> rdata_o == 8'hFF);
  assert_other_port_ff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && io_i && !we_i && addr_i != PAGE_PORT) |=> rdata_o == 8'hFF);
  assert_write_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> $stable(rdata_o));
endmodule

// File: tb/tb_pager_overlay.sv
module tb_pager_overlay;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, io = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int vecs = 0, errs = 0;
  logic m_rom = 1'b1;
  logic [7:0] shadow [2048];

  always #5 clk = ~clk;

  pager_overlay dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .io_i(io), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] rom_f(input int a);
    logic [15:0] v = 16'(a);
    return v[7:0] ^ {3'b000, v[12:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 7 + k * 29 + 3) ^ (i >> 8));
  endfunction

  function automatic logic [7:0] exp_mem(input int a);
    if (a >= 16'h2000) return 8'hFF;
    if (a >= 16'h1800 && !m_rom) return shadow[a & 16'h7FF];
    return rom_f(a);
  endfunction

  task automatic chk(input logic [7:0] exp, input string tag, input int a);
    vecs++;
    if (rdata !== exp) begin
      errs++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic access(input logic i, input logic w, input int a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; io = i; we = w; addr = 16'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic port_rd(input string tag);
    logic [7:0] e = m_rom ? 8'h80 : 8'h00;
    access(1'b1, 1'b0, 16'h02DD, 8'h00);
    m_rom = 1'b1;
    chk(e, tag, 16'h02DD);
  endtask

  task automatic port_wr(input logic [7:0] d);
    access(1'b1, 1'b1, 16'h02DD, d);
    m_rom = 1'b0;
  endtask

  task automatic mem_rd(input int a, input string tag);
    access(1'b0, 1'b0, a, 8'h00);
    chk(exp_mem(a), tag, a);
  endtask

  initial begin
    #200000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) shadow[i] = rom_f(16'h1800 + i);
    repeat (3) @(negedge clk);
    chk(8'hFF, "R1 reset rdata", 0);
    rst_n = 1'b1;
    port_rd("R1 first port read");

    // full decode sweep with ROM selected
    for (int a = 0; a < 16'h4000; a++)
      mem_rd(a, a >= 16'h2000 ? "R7 high region" : (a >= 16'h1800 ? "R6 overlay rom" : "R2 low rom"));

    // neighbouring ports leave the flag alone
    for (int p = 16'h02D0; p < 16'h02E0; p++)
      if (p != 16'h02DD) begin
        access(1'b1, 1'b0, p, 8'h00);
        chk(8'hFF, "R9 other port read", p);
        access(1'b1, 1'b1, p, 8'hAA);
      end
    access(1'b1, 1'b0, 16'h03DD, 8'h00);
    chk(8'hFF, "R9 other port read", 16'h03DD);
    port_rd("R9 flag kept rom");

    port_wr(8'h00);
    port_rd("R4 write data 00 pages ram");
    port_wr(8'hFF);
    for (int p = 16'h02D8; p < 16'h02E0; p++)
      if (p != 16'h02DD) access(1'b1, p[0], p, 8'h80);

    // reset copy visible through RAM
    for (int a = 16'h1800; a < 16'h2000; a++) mem_rd(a, "R5 ram reset copy");

    // fill overlay, then poke outside it
    for (int i = 0; i < 2048; i++) begin
      access(1'b0, 1'b1, 16'h1800 + i, pat(i, 1));
      shadow[i] = pat(i, 1);
    end
    for (int a = 0; a < 16'h1800; a += 37) access(1'b0, 1'b1, a, 8'h33);
    for (int a = 16'h2000; a < 16'h4000; a += 41) access(1'b0, 1'b1, a, 8'h44);
    access(1'b0, 1'b1, 16'h17FF, 8'h55);
    access(1'b0, 1'b1, 16'h2000, 8'h66);
    for (int a = 16'h1800; a < 16'h2000; a++) mem_rd(a, "R8 overlay write readback");
    for (int a = 0; a < 16'h1800; a += 37) mem_rd(a, "R8 low write ignored");
    for (int a = 16'h2000; a < 16'h4000; a += 41) mem_rd(a, "R8 high write ignored");
    mem_rd(16'h17FF, "R8 edge below overlay");
    mem_rd(16'h2000, "R8 edge above overlay");

    // ROM selected: overlay writes dropped
    port_rd("R3 previous state ram");
    for (int i = 0; i < 2048; i += 3) access(1'b0, 1'b1, 16'h1800 + i, pat(i, 2));
    for (int a = 16'h1800; a < 16'h2000; a += 5) mem_rd(a, "R6 overlay rom view");
    port_wr(8'h5C);
    for (int a = 16'h1800; a < 16'h2000; a++) mem_rd(a, "R8 rom-time write ignored");

    port_rd("R3 previous state ram");
    port_rd("R3 previous state rom");
    mem_rd(16'h1800, "R6 overlay rom view");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule